// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls an eight-pin bidirectional I/O port. For each pin it stores three bits: a direction bit, an output data bit and a pull-up enable bit. It also stores one port-wide control bit. Software writes and reads these through a small register bus, and the block turns them into three pad-side vectors: an output enable, an output value and a pull-up enable for each pin.

Two features go beyond plain storage. The first is an atomic toggle. A write to the toggle address inverts every output data bit whose write-data bit is one, and it leaves the direction setting alone. The second is an optional break-before-make mode. When this mode is on, a pin that changes from input to output keeps its driver off for one clock before the driver turns on. A pin that changes from output to input releases its driver at once.

Reset is asserted asynchronously and released through a two-stage synchronizer, so every pin floats as soon as reset arrives, even with no clock running. Pin-input sampling is done in a separate block.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While rst_n is low, pad_oe is all zero whether or not the clock runs. Reset clears direction, output data, pull-up enable and the mode bit.
- R2: A write to address 0 stores the direction. With the mode bit clear, pad_oe equals the stored direction from the cycle after the write edge. A bit value of 1 means output.
- R3: A write to address 1 stores the output data, and pad_out shows it from the cycle after the write edge.
- R4: A write to address 2 inverts each output data bit whose wdata bit is 1 and leaves the other bits unchanged, for any direction. Reads of address 2 return zero.
- R5: A write to address 3 stores the pull-up enables. pad_pu equals them for any direction, so a pin can drive while its pull-up is on.
- R6: Bit 0 of address 4 is the break-before-make bit. While it is set, a pin whose direction goes from 0 to 1 keeps pad_oe low for exactly one cycle after the write edge, and pad_oe goes high in the cycle after that.
- R7: A pin whose direction goes from 1 to 0 drops pad_oe in the first cycle after the write edge, whether the mode bit is set or clear.
- R8: rdata depends combinationally on addr. It returns the direction at address 0, the output data at 1, the pull-up enables at 3, and the mode bit in bit 0 at 4. All other addresses return zero.
- R9: Nothing changes unless wr_en is high at the rising edge. Writes to addresses 5 to 7 change no state.
- R10: The mode bit applies to all pins at once. Several pins turned to output in one write all spend the same single cycle tri-stated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | PIN_W | Write data |
| rdata | output | PIN_W | Combinational read data |
| pad_oe | output | PIN_W | Per-pin driver enable |
| pad_out | output | PIN_W | Per-pin drive value |
| pad_pu | output | PIN_W | Per-pin pull-up enable |

## Verification
The bench builds the block with the default PIN_W of 8 and a 3-bit address. At this width, random write data reaches every pattern of one pin turning to output while its neighbours turn to input. It also reaches all three unmapped addresses. The break-before-make mode is randomly turned on and off in the middle of direction changes. Directed cases cover all pins turning on together, toggles on input pins, and a reset applied asynchronously in the middle of a run.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int GPIO_ADDR_W = 3;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    RG_DIR = 3'd0,
    RG_OUT = 3'd1,
    RG_TGL = 3'd2,
    RG_PUE = 3'd3,
    RG_CTL = 3'd4
  } gpio_reg_e;

  localparam int CTL_BBM_BIT = 0;
endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
`timescale 1ns/1ps
module gpio_reg_file
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GPIO_ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]       wdata,
  output logic [PIN_W-1:0]       dir_q,
  output logic [PIN_W-1:0]       out_q,
  output logic [PIN_W-1:0]       pue_q,
  output logic                   bbm_q
);
  logic             dir_en, out_en, pue_en, ctl_en;
  logic [PIN_W-1:0] out_nxt;

  always_comb begin
    dir_en  = wr_en && (addr == RG_DIR);
    pue_en  = wr_en && (addr == RG_PUE);
    ctl_en  = wr_en && (addr == RG_CTL);
    out_en  = wr_en && ((addr == RG_OUT) || (addr == RG_TGL));
    out_nxt = (addr == RG_TGL) ? (out_q ^ wdata) : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      pue_q <= '0;
      bbm_q <= 1'b0;
    end else begin
      if (dir_en) dir_q <= wdata;
      if (out_en) out_q <= out_nxt;
      if (pue_en) pue_q <= wdata;
      if (ctl_en) bbm_q <= wdata[CTL_BBM_BIT];
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
module gpio_pin_drive #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] dir_q,
  input  logic             bbm_q,
  output logic [PIN_W-1:0] oe
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    logic dir_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_d <= 1'b0;
      else        dir_d <= dir_q[i];
    end

    assign oe[i] = dir_q[i] & (~bbm_q | dir_d);
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [GPIO_ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]       wdata,
  output logic [PIN_W-1:0]       rdata,
  output logic [PIN_W-1:0]       pad_oe,
  output logic [PIN_W-1:0]       pad_out,
  output logic [PIN_W-1:0]       pad_pu
);
  logic             rst_int_n;
  logic [PIN_W-1:0] dir_q, out_q, pue_q, oe_int;
  logic             bbm_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  gpio_reg_file #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .out_q(out_q), .pue_q(pue_q), .bbm_q(bbm_q)
  );

  gpio_pin_drive #(.PIN_W(PIN_W)) u_drv (
    .clk(clk), .rst_n(rst_int_n), .dir_q(dir_q), .bbm_q(bbm_q), .oe(oe_int)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      RG_DIR:  rdata = dir_q;
      RG_OUT:  rdata = out_q;
      RG_PUE:  rdata = pue_q;
      RG_CTL:  rdata[CTL_BBM_BIT] = bbm_q;
      default: rdata = '0;
    endcase
  end

  assign pad_oe  = oe_int;
  assign pad_out = out_q;
  assign pad_pu  = pue_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_port_ctrl_chk #(
  parameter int PIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [PIN_W-1:0] wdata,
  input logic [PIN_W-1:0] pad_oe,
  input logic [PIN_W-1:0] pad_out,
  input logic [PIN_W-1:0] dir_q,
  input logic             bbm_q
);
  // R1: no driver enabled while reset is held
  a_r1_reset_floats: assert property (@(posedge clk)
    !rst_n |-> pad_oe == '0);

  // R3: a data write shows on the pads one cycle later
  a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 3'd1) |=> pad_out == $past(wdata));

  // R4: a toggle write inverts the selected bits
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 3'd2) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

  // R2: with the mode off, the enable follows the direction
  a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bbm_q |-> pad_oe == dir_q);

  // R6 and R10: with the mode on, no pin drives in the cycle its direction rises
  a_r6_bbm_gap: assert property (@(posedge clk) disable iff (!rst_int_n)
    bbm_q |-> (pad_oe & ~$past(dir_q)) == '0);

  // R7: input pins never drive
  a_r7_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pad_oe & ~dir_q) == '0);

  // R9: a cycle without a write leaves the data unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |=> $stable(pad_out));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .pad_oe(pad_oe), .pad_out(pad_out),
  .dir_q(dir_q), .bbm_q(bbm_q)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wdata, rdata, pad_oe, pad_out, pad_pu;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_dir, m_out, m_pue, m_dprev;
  logic         m_bbm;
  logic         m_live;

  gpio_port_ctrl #(.PIN_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] exp_oe();
    return m_dir & (m_bbm ? m_dprev : {W{1'b1}});
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_out;
      3'd3: return m_pue;
      3'd4: return {{(W-1){1'b0}}, m_bbm};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_dir = '0; m_out = '0; m_pue = '0; m_dprev = '0; m_bbm = 1'b0;
  endtask

  // One clock: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input logic we, input logic [2:0] a,
                      input logic [W-1:0] d, input string tag);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    m_dprev = m_dir;
    if (we && m_live) begin
      case (a)
        3'd0: m_dir = d;
        3'd1: m_out = d;
        3'd2: m_out = m_out ^ d;
        3'd3: m_pue = d;
        3'd4: m_bbm = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, "pad_oe",  pad_oe,  exp_oe());
    chk(tag, "pad_out", pad_out, m_out);
    chk(tag, "pad_pu",  pad_pu,  m_pue);
    chk(tag, "rdata",   rdata,   exp_rd(a));
  endtask

  task automatic do_reset();
    #1 rst_n = 1'b0;
    model_clear();
    m_live = 1'b0;
    #2 chk("R1", "pad_oe async", pad_oe, '0);
    chk("R1", "pad_pu async", pad_pu, '0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 3'd0, 8'hFF, "R1");
    step(1'b0, 3'd0, 8'h00, "R1");
    m_live = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    model_clear();
    m_live = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 / R3 / R5 basics with mode off
    step(1'b1, 3'd0, 8'hA5, "R2");
    step(1'b1, 3'd1, 8'h3C, "R3");
    step(1'b1, 3'd3, 8'hF0, "R5");
    step(1'b0, 3'd3, 8'h00, "R8");
    // R4 toggle independent of direction, read of toggle address is zero
    step(1'b1, 3'd0, 8'h00, "R7");
    step(1'b1, 3'd2, 8'h81, "R4");
    step(1'b1, 3'd2, 8'h00, "R4");
    // R9 unmapped writes and wr_en low
    step(1'b1, 3'd5, 8'hFF, "R9");
    step(1'b1, 3'd7, 8'hFF, "R9");
    step(1'b0, 3'd1, 8'hFF, "R9");
    step(1'b0, 3'd4, 8'hFF, "R8");
    // R6 / R10 break-before-make: all pins turn to output at once
    step(1'b1, 3'd4, 8'h01, "R6");
    step(1'b1, 3'd0, 8'hFF, "R10");
    chk("R10", "oe gap", pad_oe, 8'h00);
    step(1'b0, 3'd0, 8'h00, "R6");
    chk("R6", "oe after gap", pad_oe, 8'hFF);
    // R7 output to input drops at once with mode on
    step(1'b1, 3'd0, 8'h0F, "R7");
    chk("R7", "oe drop", pad_oe, 8'h0F);
    step(1'b1, 3'd0, 8'hF0, "R6");
    chk("R6", "mixed swap", pad_oe, 8'h00);
    step(1'b0, 3'd4, 8'h00, "R8");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      step(($urandom % 4) != 0, a, W'($urandom), "R2");
    end

    // Asynchronous reset in mid-run
    step(1'b1, 3'd4, 8'h00, "R2");
    step(1'b1, 3'd0, 8'hFF, "R2");
    do_reset();
    step(1'b0, 3'd0, 8'h00, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule